// File: doc/BRIEF.md
# Piecewise Linear Sensor Code to Temperature Converter

This block turns a 12-bit thermal sensor code into a signed temperature in millidegrees Celsius. The transfer curve is made of two straight lines, each given by a fixed-point slope and offset with 7 fractional bits. The coefficients and a breakpoint code arrive on plain input ports that the surrounding logic holds steady. A single start pulse hands over a code. One conversion later a one-cycle done pulse presents the rounded temperature together with an error flag.

Internally the block chooses a segment by comparing the code with the breakpoint. It forms the fixed-point dividend and divides it by the slope in a shared bit-serial restoring divider that rounds to nearest. It scales the quotient to millidegrees and checks the legal window. It then reuses the same divider to snap the value to a 500 millidegree grid with symmetric rounding. A zero slope in the chosen segment is reported as an error at once, and no division is started.

Top module: `pwl_temp_conv`

## Requirements
- R1: While reset is asserted and after it is released, before any conversion, done, err and temp_mc are all 0.
- R2: The code and breakpoint are compared as unsigned numbers. A code less than or equal to brk_code uses seg1_slope/seg1_offset, and a larger code uses seg2_slope/seg2_offset. For example, code 0xFFF against breakpoint 0x800 selects segment 2.
- R3: The fixed-point quotient is val = round(((code*128 − offset)*128) / slope). Ties are rounded away from zero, and the sign is the product of the operand signs.
- R4: The millidegree value is mc = floor(val*1000 / 128), an arithmetic right shift by 7.
- R5: When mc < −40000 or mc > 125000, done comes with err = 1 and temp_mc = 0. The limits themselves are legal.
- R6: A legal mc is rounded to a multiple of 500: (|mc| + 250) / 500 truncated, times 500, with the sign of mc restored. So ±250 becomes ±500 and 242 becomes 0.
- R7: A zero slope in the selected segment gives done with err = 1 and temp_mc = 0 in the cycle after the start is accepted. A zero slope in the other segment has no effect.
- R8: done is high for exactly one cycle per accepted start. A start while a conversion is running is ignored: it produces no extra done and does not change the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a conversion of `code` (taken only when idle) |
| code | input | 12 | Unsigned sensor code |
| brk_code | input | 12 | Unsigned breakpoint code between the segments |
| seg1_slope | input | 32 | Signed slope of segment 1, 7 fractional bits |
| seg1_offset | input | 32 | Signed offset of segment 1, 7 fractional bits |
| seg2_slope | input | 32 | Signed slope of segment 2, 7 fractional bits |
| seg2_offset | input | 32 | Signed offset of segment 2, 7 fractional bits |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Result is out of range or the slope was zero; valid with done |
| temp_mc | output | 32 | Signed temperature in millidegrees; valid with done |

## Verification
The cycle-level checks cover the result-strobe rules. done is always a single-cycle pulse, an error result carries zero, a good result lies inside the legal window on the 500 grid, a zero selected slope answers in the next cycle, and a normal start never answers in the next cycle. Only the directed scenarios can show the arithmetic itself: which segment an unsigned comparison picks, rounding ties of the divider and of the 500 step in both signs, a negative slope, both range limits and their first illegal neighbours, and a start issued mid-conversion leaving the result untouched.

// File: rtl/pwl_conv_pkg.sv
package pwl_conv_pkg;
  localparam int FRAC_BITS  = 7;
  localparam int MC_PER_DEG = 1000;
  localparam int MC_MIN     = -40000;
  localparam int MC_MAX     = 125000;
  localparam int MC_STEP    = 500;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV1,
    ST_SCALE,
    ST_DIV2
  } conv_state_t;
endpackage

// File: rtl/pwl_divider.sv
// Bit-serial restoring divider on unsigned magnitudes, one quotient bit per cycle.
module pwl_divider #(
  parameter int DW = 41,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dvd,
  input  logic [VW-1:0] dvs,
  output logic          done,
  output logic [DW-1:0] quo
);
  localparam int CW = $clog2(DW);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [VW-1:0] rem_q, rem_d;
  logic [VW-1:0] dvs_q, dvs_d;
  logic [VW:0]   trial;
  logic          fits;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    trial  = {rem_q, quo_q[DW-1]};
    fits   = trial >= {1'b0, dvs_q};
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      quo_d  = dvd;
      rem_d  = '0;
      dvs_d  = dvs;
    end else if (busy_q) begin
      quo_d = {quo_q[DW-2:0], fits};
      rem_d = VW'(fits ? trial - {1'b0, dvs_q} : trial);
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(DW-1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/pwl_seg_select.sv
// Segment choice and first-pass divider operands (magnitudes plus half-divisor rounding).
module pwl_seg_select import pwl_conv_pkg::*; #(
  parameter int CODE_W = 12,
  parameter int COEF_W = 32,
  parameter int DW     = COEF_W + FRAC_BITS + 2
) (
  input  logic [CODE_W-1:0]        code,
  input  logic [CODE_W-1:0]        brk,
  input  logic signed [COEF_W-1:0] a1,
  input  logic signed [COEF_W-1:0] b1,
  input  logic signed [COEF_W-1:0] a2,
  input  logic signed [COEF_W-1:0] b2,
  output logic [DW-1:0]            dvd_mag,
  output logic [COEF_W-1:0]        dvs_mag,
  output logic                     q_neg,
  output logic                     slope_zero
);
  localparam int PAD_W = COEF_W + 1 - CODE_W - FRAC_BITS;

  logic                     use_seg2;
  logic signed [COEF_W-1:0] a_sel, b_sel;
  logic signed [COEF_W:0]   diff;
  logic [COEF_W:0]          diff_mag;

  always_comb begin
    use_seg2   = code > brk;
    a_sel      = use_seg2 ? a2 : a1;
    b_sel      = use_seg2 ? b2 : b1;
    diff       = $signed({{PAD_W{1'b0}}, code, {FRAC_BITS{1'b0}}})
               - $signed({b_sel[COEF_W-1], b_sel});
    diff_mag   = diff[COEF_W] ? -diff : diff;
    dvs_mag    = a_sel[COEF_W-1] ? -a_sel : a_sel;
    dvd_mag    = DW'({diff_mag, {FRAC_BITS{1'b0}}}) + DW'(dvs_mag >> 1);
    q_neg      = diff[COEF_W] ^ a_sel[COEF_W-1];
    slope_zero = (a_sel == '0);
  end
endmodule

// File: rtl/pwl_scale.sv
// Millidegree scaling, range window and second-pass (grid rounding) dividend.
module pwl_scale import pwl_conv_pkg::*; #(
  parameter int DW   = 41,
  parameter int MC_W = DW + 12
) (
  input  logic signed [DW:0] val,
  output logic               range_err,
  output logic               mc_neg,
  output logic [DW-1:0]      mag_rnd
);
  localparam logic signed [MC_W-1:0] MC_LO = MC_W'(MC_MIN);
  localparam logic signed [MC_W-1:0] MC_HI = MC_W'(MC_MAX);

  logic signed [MC_W-1:0] prod, mc;

  always_comb begin
    prod      = MC_W'(val) * MC_W'(MC_PER_DEG);
    mc        = prod >>> FRAC_BITS;
    range_err = (mc < MC_LO) || (mc > MC_HI);
    mc_neg    = mc[MC_W-1];
    mag_rnd   = DW'(mc_neg ? -mc : mc) + DW'(MC_STEP / 2);
  end
endmodule

// File: rtl/pwl_temp_conv.sv
module pwl_temp_conv import pwl_conv_pkg::*; #(
  parameter int CODE_W = 12,
  parameter int COEF_W = 32,
  parameter int TEMP_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CODE_W-1:0]        code,
  input  logic [CODE_W-1:0]        brk_code,
  input  logic signed [COEF_W-1:0] seg1_slope,
  input  logic signed [COEF_W-1:0] seg1_offset,
  input  logic signed [COEF_W-1:0] seg2_slope,
  input  logic signed [COEF_W-1:0] seg2_offset,
  output logic                     done,
  output logic                     err,
  output logic signed [TEMP_W-1:0] temp_mc
);
  localparam int DW   = COEF_W + FRAC_BITS + 2;
  localparam int MC_W = DW + 12;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  conv_state_t       state_q, state_d;
  logic signed [DW:0] val_q, val_d;
  logic               qneg_q, qneg_d;
  logic               mneg_q, mneg_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic [TEMP_W-1:0]  temp_q, temp_d;

  logic [DW-1:0]      sel_dvd;
  logic [COEF_W-1:0]  sel_dvs;
  logic               sel_qneg, sel_zero;
  logic               sc_err, sc_neg;
  logic [DW-1:0]      sc_mag;
  logic               div_start, div_done;
  logic [DW-1:0]      div_dvd, div_q;
  logic [COEF_W-1:0]  div_dvs;
  logic [TEMP_W-1:0]  t_mag;
  logic               accept;

  pwl_seg_select #(.CODE_W(CODE_W), .COEF_W(COEF_W), .DW(DW)) i_sel (
    .code(code), .brk(brk_code),
    .a1(seg1_slope), .b1(seg1_offset), .a2(seg2_slope), .b2(seg2_offset),
    .dvd_mag(sel_dvd), .dvs_mag(sel_dvs), .q_neg(sel_qneg), .slope_zero(sel_zero)
  );

  pwl_scale #(.DW(DW), .MC_W(MC_W)) i_scale (
    .val(val_q), .range_err(sc_err), .mc_neg(sc_neg), .mag_rnd(sc_mag)
  );

  pwl_divider #(.DW(DW), .VW(COEF_W)) i_div (
    .clk(clk), .rst_n(rst_ok), .start(div_start),
    .dvd(div_dvd), .dvs(div_dvs), .done(div_done), .quo(div_q)
  );

  assign accept = start && (state_q == ST_IDLE);
  assign t_mag  = TEMP_W'(div_q) * TEMP_W'(MC_STEP);

  always_comb begin
    state_d   = state_q;
    val_d     = val_q;
    qneg_d    = qneg_q;
    mneg_d    = mneg_q;
    done_d    = 1'b0;
    err_d     = err_q;
    temp_d    = temp_q;
    div_start = 1'b0;
    div_dvd   = sel_dvd;
    div_dvs   = sel_dvs;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          qneg_d = sel_qneg;
          if (sel_zero) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            temp_d = '0;
          end else begin
            div_start = 1'b1;
            state_d   = ST_DIV1;
          end
        end
      end
      ST_DIV1: begin
        if (div_done) begin
          val_d   = qneg_q ? -$signed({1'b0, div_q}) : $signed({1'b0, div_q});
          state_d = ST_SCALE;
        end
      end
      ST_SCALE: begin
        if (sc_err) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          temp_d  = '0;
          state_d = ST_IDLE;
        end else begin
          mneg_d    = sc_neg;
          div_start = 1'b1;
          div_dvd   = sc_mag;
          div_dvs   = COEF_W'(MC_STEP);
          state_d   = ST_DIV2;
        end
      end
      ST_DIV2: begin
        if (div_done) begin
          done_d  = 1'b1;
          err_d   = 1'b0;
          temp_d  = mneg_q ? -t_mag : t_mag;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q <= ST_IDLE;
      val_q   <= '0;
      qneg_q  <= 1'b0;
      mneg_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      temp_q  <= '0;
    end else begin
      state_q <= state_d;
      val_q   <= val_d;
      qneg_q  <= qneg_d;
      mneg_q  <= mneg_d;
      done_q  <= done_d;
      err_q   <= err_d;
      temp_q  <= temp_d;
    end
  end

  assign done    = done_q;
  assign err     = err_q;
  assign temp_mc = temp_q;
endmodule

// File: rtl/pwl_temp_conv_chk.sv
module pwl_temp_conv_chk #(
  parameter int TEMP_W = 32
) (
  input logic                     clk,
  input logic                     rst_ok,
  input logic                     done,
  input logic                     err,
  input logic signed [TEMP_W-1:0] temp,
  input logic                     accept,
  input logic                     sel_zero
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);

  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && err) |-> (temp == 0));

  a_r5_in_window: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && !err) |-> (temp >= -40000 && temp <= 125000));

  a_r6_on_grid: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && !err) |-> ((temp % 500) == 0));

  a_r7_zero_slope: assert property (@(posedge clk) disable iff (!rst_ok)
    (accept && sel_zero) |=> (done && err));

  a_r8_no_early_done: assert property (@(posedge clk) disable iff (!rst_ok)
    (accept && !sel_zero) |=> !done);
endmodule

bind pwl_temp_conv pwl_temp_conv_chk #(.TEMP_W(TEMP_W)) i_chk (
  .clk(clk), .rst_ok(rst_ok), .done(done), .err(err), .temp(temp_mc),
  .accept(accept), .sel_zero(sel_zero)
);

// File: tb/test_pwl_temp_conv.sv
module test_pwl_temp_conv;
  logic               clk;
  logic               rst_n;
  logic               start;
  logic [11:0]        code;
  logic [11:0]        brk;
  logic signed [31:0] a1, b1, a2, b2;
  logic               done, err;
  logic signed [31:0] temp;

  int n_chk;
  int n_bad;

  pwl_temp_conv i_pwl_temp_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code), .brk_code(brk),
    .seg1_slope(a1), .seg1_offset(b1), .seg2_slope(a2), .seg2_offset(b2),
    .done(done), .err(err), .temp_mc(temp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model written from the requirements
  task automatic model(input logic [11:0] c, output longint t, output bit e);
    longint a, b, x, ax, ad, m, q, mc;
    if (c <= brk) begin a = longint'(a1); b = longint'(b1); end
    else          begin a = longint'(a2); b = longint'(b2); end
    e = 1'b0; t = 0;
    if (a == 0) begin e = 1'b1; return; end
    x  = ((longint'(c) * 128) - b) * 128;
    ax = (x < 0) ? -x : x;
    ad = (a < 0) ? -a : a;
    m  = (ax + ad / 2) / ad;
    q  = ((x < 0) != (a < 0)) ? -m : m;
    mc = (q * 1000) >>> 7;
    if (mc < -40000 || mc > 125000) begin e = 1'b1; return; end
    m = (((mc < 0) ? -mc : mc) + 250) / 500;
    t = (mc < 0) ? -(m * 500) : m * 500;
  endtask

  task automatic run_conv(input string req, input logic [11:0] c,
                          output longint t, output bit e, output int cyc);
    @(negedge clk); code = c; start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
    check({req, " done seen"}, longint'(done), 1);
    t = longint'(temp); e = err;
    @(negedge clk);
    check("R8 done one cycle", longint'(done), 0);
  endtask

  task automatic conv_vs_model(input string req, input logic [11:0] c);
    longint t, te; bit e, ee; int cyc;
    model(c, te, ee);
    run_conv(req, c, t, e, cyc);
    check({req, " err"}, longint'(e), longint'(ee));
    check({req, " temp"}, t, te);
  endtask

  task automatic conv_expect(input string req, input logic [11:0] c,
                             input longint te, input bit ee);
    longint t; bit e; int cyc;
    run_conv(req, c, t, e, cyc);
    check({req, " err"}, longint'(e), longint'(ee));
    check({req, " temp"}, t, te);
  endtask

  task automatic t_reset;
    check("R1 done in reset", longint'(done), 0);
    check("R1 err in reset", longint'(err), 0);
    check("R1 temp in reset", longint'(temp), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done after reset", longint'(done), 0);
    check("R1 temp after reset", longint'(temp), 0);
  endtask

  task automatic t_calibrated;
    brk = 12'd2800;
    a1 = 32'sd965; b1 = 32'sd323853;
    a2 = 32'sd847; b2 = 32'sd328094;
    conv_vs_model("R3 R4 seg1 mid", 12'd2500);
    conv_vs_model("R2 at breakpoint", 12'd2800);
    conv_expect("R2 R6 at breakpoint value", 12'd2800, 36000, 1'b0);
    conv_vs_model("R2 above breakpoint", 12'd2801);
    conv_vs_model("R3 R4 seg2 mid", 12'd3300);
    conv_expect("R5 cold limit", 12'd2221, 0, 1'b1);
    conv_expect("R5 hot limit", 12'd3397, 0, 1'b1);
  endtask

  task automatic t_unsigned_select;
    a1 = 32'sd128; b1 = 32'sd4045 * 128;
    a2 = 32'sd128; b2 = 32'sd4075 * 128;
    brk = 12'h800;
    conv_expect("R2 unsigned code 0xFFF picks seg2", 12'hFFF, 20000, 1'b0);
    brk = 12'hFFF;
    conv_expect("R2 code equal breakpoint picks seg1", 12'hFFF, 50000, 1'b0);
  endtask

  task automatic t_rounding;
    brk = 12'hFFF; a2 = 32'sd128; b2 = 0;
    a1 = 32'sd256; b1 = 32'sd12800 - 63;
    conv_expect("R3 divider tie positive", 12'd100, 500, 1'b0);
    b1 = 32'sd12800 + 63;
    conv_expect("R3 divider tie negative", 12'd100, -500, 1'b0);
    a1 = 32'sd128; b1 = 32'sd12800 - 31;
    conv_expect("R6 below half step", 12'd100, 0, 1'b0);
    b1 = 32'sd12800 + 32;
    conv_expect("R6 negative half step", 12'd100, -500, 1'b0);
    b1 = 32'sd12800 - 64;
    conv_expect("R4 scale 64 to 500", 12'd100, 500, 1'b0);
    a1 = -32'sd128; b1 = 32'sd12800 + 32;
    conv_expect("R3 negative slope", 12'd100, 500, 1'b0);
  endtask

  task automatic t_range;
    brk = 12'hFFF; a1 = 32'sd128; a2 = 32'sd128; b2 = 0;
    b1 = 32'sd12800 + 5120;
    conv_expect("R5 low limit legal", 12'd100, -40000, 1'b0);
    b1 = 32'sd12800 + 5121;
    conv_expect("R5 below low limit", 12'd100, 0, 1'b1);
    b1 = 32'sd12800 - 16000;
    conv_expect("R5 high limit legal", 12'd100, 125000, 1'b0);
    b1 = 32'sd12800 - 16001;
    conv_expect("R5 above high limit", 12'd100, 0, 1'b1);
  endtask

  task automatic t_zero_slope;
    longint t; bit e; int cyc;
    brk = 12'd2000; a1 = 0; b1 = 32'sd1000; a2 = 32'sd128; b2 = 32'sd1990 * 128;
    run_conv("R7 zero slope", 12'd1500, t, e, cyc);
    check("R7 zero slope err", longint'(e), 1);
    check("R7 zero slope temp", t, 0);
    check("R7 zero slope latency", longint'(cyc), 1);
    conv_expect("R7 unused segment zero slope", 12'd2030, 40000, 1'b0);
  endtask

  task automatic t_busy_start;
    longint te; bit ee; int cyc; int extra;
    brk = 12'hFFF; a1 = 32'sd128; b1 = 32'sd12800 - 2560; a2 = 32'sd128; b2 = 0;
    model(12'd100, te, ee);
    @(negedge clk); code = 12'd100; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    code = 12'd3000; start = 1'b1;
    @(negedge clk); start = 1'b0; code = 12'd0; cyc = 0;
    while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
    check("R8 busy done seen", longint'(done), 1);
    check("R8 busy start ignored err", longint'(err), longint'(ee));
    check("R8 busy start ignored temp", longint'(temp), te);
    check("R8 busy start ignored temp value", longint'(temp), 20000);
    extra = 0;
    repeat (150) begin @(negedge clk); if (done) extra++; end
    check("R8 no extra done", longint'(extra), 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; code = '0; brk = '0;
    a1 = 0; b1 = 0; a2 = 0; b2 = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_calibrated();
    t_unsigned_select();
    t_rounding();
    t_range();
    t_zero_slope();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule